// File: doc/BRIEF.md
# Power-down clock stop sequencer

This block stops a group of gated output clocks cleanly when the board asks for power-down, and brings them back without glitches when the request goes away. Every source clock arrives as a level sampled by a fast system clock. That covers the single-ended sources and the true and complement halves of each differential pair. Each output is either passed through or parked at a fixed level.

One pin serves two purposes. Its first rising edge marks power-good, and on that edge the strap inputs (frequency select and CPU select) are captured for good. From then on the same pin, when low, is an active-low power-down request. The request passes through a synchronizer. It is honoured only after the sequencer has seen it on two consecutive rising edges of a chosen complement reference clock. Each output then parks on its own next falling edge of the clock it watches. A differential pair is parked either with its true side driven high or with both sides floated, according to a per-pair mode bit.

Top module: `pd_clk_stop_seq`

## Requirements
- R1: While reset is applied, every single-ended output is 0, every true output is 1, every complement output is 0 with its enable 0, `parked_o` is 1 and `strap_vld_o` is 0.
- R2: On the first rising edge of the synchronized power-good pin, `strap_i` is captured into `strap_q_o` and `strap_vld_o` goes to 1 and stays 1.
- R3: The pin passes through two flip-flops before use. Before its first rising edge, all outputs stay parked. After that edge, a low level on the pin is a power-down request.
- R4: Outputs are stopped only after the request has been seen at two consecutive rising edges of the complement source of pair `REF_PAIR`. A request that spans fewer such edges stops nothing.
- R5: After the stop decision, each single-ended output follows its source until the source's next falling edge and is 0 from then on, so no high pulse is shortened.
- R6: After the stop decision, each true output follows its source until the next falling edge of its complement source and is 1 from then on. Its complement output is 0.
- R7: While a pair is parked, a mode bit of 0 gives true enable 1 and complement enable 0. A mode bit of 1 gives both enables 0. While the pair runs, both enables are 1.
- R8: Once the request is removed, each output resumes in the first low phase of the clock it watches (its own source for single-ended outputs, the complement source for pairs). The first output pulse is therefore full width and no runt pulse is produced.
- R9: `parked_o` is 1 exactly when every single-ended and differential output is in its parked state.
- R10: Later edges of the pin do not change `strap_q_o` until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_pd_i | input | 1 | Power-good on first rise, active-low power-down afterwards |
| strap_i | input | STRAP_W | Strap pins captured at power-good |
| se_src_i | input | N_SE | Single-ended source clock levels |
| dp_src_t_i | input | N_DP | True source levels of differential pairs |
| dp_src_c_i | input | N_DP | Complement source levels of differential pairs |
| drive_mode_i | input | N_DP | Per-pair park mode, 0 drive true high, 1 float both |
| se_clk_o | output | N_SE | Gated single-ended outputs |
| dp_t_o | output | N_DP | Gated true outputs |
| dp_c_o | output | N_DP | Gated complement outputs |
| dp_t_oe_o | output | N_DP | True output enables |
| dp_c_oe_o | output | N_DP | Complement output enables |
| strap_q_o | output | STRAP_W | Captured strap value |
| strap_vld_o | output | 1 | Strap value has been captured |
| parked_o | output | 1 | All outputs parked |

## Verification
The alignment assertions assume that every source clock changes at most once per sampling cycle and holds each phase for at least one full sample. They also assume that the complement of a pair is always the inverse of its true source. The bench meets this by generating all sources as fixed-period square waves, with the complement built by inversion and every edge driven on the falling system edge. The power-down pin, the straps and the mode bits change at random, and so do the pin's hold times. Directed sequences cover the request shorter than one reference period, a long stop with mixed park modes, and the restart that follows.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic {
    PARK_DRIVE_TRUE = 1'b0,
    PARK_FLOAT      = 1'b1
  } park_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned STOP_HITS   = 2;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pd_stop_ctrl.sv
module pd_stop_ctrl #(
  parameter int unsigned STRAP_W = 4,
  parameter int unsigned HITS    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pg_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               ref_i,
  output logic               stop_o,
  output logic [STRAP_W-1:0] strap_q_o,
  output logic               strap_vld_o
);
  localparam int unsigned CW = $clog2(HITS + 1);

  logic               armed_q, ref_q, stop_q;
  logic [CW-1:0]      cnt_q;
  logic [STRAP_W-1:0] strap_q;
  logic               pd_req, ref_rise;

  // before arming, the pin low means "not yet powered"
  assign pd_req   = !(armed_q && pg_i);
  assign ref_rise = ref_i && !ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      strap_q <= '0;
      ref_q   <= 1'b0;
      cnt_q   <= '0;
      stop_q  <= 1'b1;
    end else begin
      ref_q <= ref_i;
      if (pg_i && !armed_q) begin
        armed_q <= 1'b1;
        strap_q <= strap_i;
      end
      if (!pd_req) begin
        cnt_q  <= '0;
        stop_q <= 1'b0;
      end else if (ref_rise && !stop_q) begin
        if (cnt_q == CW'(HITS - 1)) stop_q <= 1'b1;
        else                        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign stop_o      = stop_q;
  assign strap_q_o   = strap_q;
  assign strap_vld_o = armed_q;
endmodule

// File: rtl/clk_park_cell.sv
module clk_park_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic watch_i,
  input  logic stop_i,
  output logic run_o
);
  logic prev_q, run_q;

  // park on falling edge of watched clock, resume while it is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      prev_q <= watch_i;
      if (run_q && stop_i && prev_q && !watch_i) run_q <= 1'b0;
      else if (!run_q && !stop_i && !watch_i)    run_q <= 1'b1;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/pd_clk_stop_seq.sv
module pd_clk_stop_seq
  import pd_seq_pkg::*;
#(
  parameter int unsigned N_SE     = 2,
  parameter int unsigned N_DP     = 2,
  parameter int unsigned STRAP_W  = 4,
  parameter int unsigned REF_PAIR = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pg_pd_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [N_SE-1:0]    se_src_i,
  input  logic [N_DP-1:0]    dp_src_t_i,
  input  logic [N_DP-1:0]    dp_src_c_i,
  input  logic [N_DP-1:0]    drive_mode_i,
  output logic [N_SE-1:0]    se_clk_o,
  output logic [N_DP-1:0]    dp_t_o,
  output logic [N_DP-1:0]    dp_c_o,
  output logic [N_DP-1:0]    dp_t_oe_o,
  output logic [N_DP-1:0]    dp_c_oe_o,
  output logic [STRAP_W-1:0] strap_q_o,
  output logic               strap_vld_o,
  output logic               parked_o
);
  logic            pg_s, stop;
  logic [N_SE-1:0] se_run;
  logic [N_DP-1:0] dp_run;

  pd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pg_pd_i),
    .q_o   (pg_s)
  );

  pd_stop_ctrl #(.STRAP_W(STRAP_W), .HITS(STOP_HITS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pg_i       (pg_s),
    .strap_i    (strap_i),
    .ref_i      (dp_src_c_i[REF_PAIR]),
    .stop_o     (stop),
    .strap_q_o  (strap_q_o),
    .strap_vld_o(strap_vld_o)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    clk_park_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .watch_i(se_src_i[i]),
      .stop_i (stop),
      .run_o  (se_run[i])
    );
    assign se_clk_o[i] = se_run[i] & se_src_i[i];
  end

  for (genvar i = 0; i < N_DP; i++) begin : g_dp
    clk_park_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .watch_i(dp_src_c_i[i]),
      .stop_i (stop),
      .run_o  (dp_run[i])
    );
    assign dp_t_o[i]    = dp_run[i] ? dp_src_t_i[i] : 1'b1;
    assign dp_c_o[i]    = dp_run[i] ? dp_src_c_i[i] : 1'b0;
    assign dp_t_oe_o[i] = dp_run[i] | (park_mode_e'(drive_mode_i[i]) == PARK_DRIVE_TRUE);
    assign dp_c_oe_o[i] = dp_run[i];
  end

  assign parked_o = ~|{se_run, dp_run};
endmodule

// File: rtl/pd_clk_stop_seq_chk.sv
module pd_clk_stop_seq_chk #(
  parameter int unsigned N_SE    = 2,
  parameter int unsigned N_DP    = 2,
  parameter int unsigned STRAP_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SE-1:0]    se_src_i,
  input logic [N_DP-1:0]    dp_src_t_i,
  input logic [N_DP-1:0]    drive_mode_i,
  input logic [N_SE-1:0]    se_clk_o,
  input logic [N_DP-1:0]    dp_t_o,
  input logic [N_DP-1:0]    dp_t_oe_o,
  input logic [N_DP-1:0]    dp_c_oe_o,
  input logic [STRAP_W-1:0] strap_q_o,
  input logic               strap_vld_o,
  input logic               parked_o
);
  for (genvar i = 0; i < N_SE; i++) begin : g_se
    AST_SE_FALL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(se_clk_o[i]) |-> $fell(se_src_i[i])); // R5
    AST_SE_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(se_clk_o[i]) |-> $rose(se_src_i[i])); // R8
  end

  for (genvar i = 0; i < N_DP; i++) begin : g_dp
    AST_DP_FALL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dp_t_o[i]) |-> $fell(dp_src_t_i[i])); // R6
    AST_DP_OE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dp_c_oe_o[i] |-> (dp_t_oe_o[i] == !drive_mode_i[i])); // R7
  end

  AST_PARKED_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_o |-> (se_clk_o == '0 && (&dp_t_o) && dp_c_oe_o == '0)); // R9
  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_vld_o |=> (strap_vld_o && $stable(strap_q_o))); // R10
endmodule

bind pd_clk_stop_seq pd_clk_stop_seq_chk #(
  .N_SE(N_SE), .N_DP(N_DP), .STRAP_W(STRAP_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .se_src_i    (se_src_i),
  .dp_src_t_i  (dp_src_t_i),
  .drive_mode_i(drive_mode_i),
  .se_clk_o    (se_clk_o),
  .dp_t_o      (dp_t_o),
  .dp_t_oe_o   (dp_t_oe_o),
  .dp_c_oe_o   (dp_c_oe_o),
  .strap_q_o   (strap_q_o),
  .strap_vld_o (strap_vld_o),
  .parked_o    (parked_o)
);

// File: tb/test_pd_clk_stop_seq.sv
module test_pd_clk_stop_seq;
  localparam int N_SE = 2;
  localparam int N_DP = 2;
  localparam int SW   = 4;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic pg_pd_i;
  logic [SW-1:0]   strap_i;
  logic [N_SE-1:0] se_src_i;
  logic [N_DP-1:0] dp_src_t_i, dp_src_c_i, drive_mode_i;
  logic [N_SE-1:0] se_clk_o;
  logic [N_DP-1:0] dp_t_o, dp_c_o, dp_t_oe_o, dp_c_oe_o;
  logic [SW-1:0]   strap_q_o;
  logic            strap_vld_o, parked_o;

  always #2 clk_i = ~clk_i;

  pd_clk_stop_seq #(.N_SE(N_SE), .N_DP(N_DP), .STRAP_W(SW), .REF_PAIR(0)) i_pd_clk_stop_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_pd_i(pg_pd_i), .strap_i(strap_i),
    .se_src_i(se_src_i), .dp_src_t_i(dp_src_t_i), .dp_src_c_i(dp_src_c_i),
    .drive_mode_i(drive_mode_i), .se_clk_o(se_clk_o), .dp_t_o(dp_t_o), .dp_c_o(dp_c_o),
    .dp_t_oe_o(dp_t_oe_o), .dp_c_oe_o(dp_c_oe_o), .strap_q_o(strap_q_o),
    .strap_vld_o(strap_vld_o), .parked_o(parked_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  logic m_s1, m_s2, m_armed, m_hit, m_stop, m_refp;
  logic [SW-1:0]   m_strap;
  logic [N_SE-1:0] m_se_run, m_se_prev;
  logic [N_DP-1:0] m_dp_run, m_dp_prev;
  int se_hi[N_SE], dp_lo[N_DP];

  function automatic int se_half(int i); return (i == 0) ? 4 : 3; endfunction
  function automatic int dp_half(int i); return (i == 0) ? 5 : 6; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic drive_src();
    for (int i = 0; i < N_SE; i++) se_src_i[i] = (cyc % (2*se_half(i))) < se_half(i);
    for (int i = 0; i < N_DP; i++) begin
      dp_src_t_i[i] = (cyc % (2*dp_half(i))) < dp_half(i);
      dp_src_c_i[i] = ~dp_src_t_i[i];
    end
  endtask

  task automatic model_step();
    logic req, rise, n_stop, n_hit;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_armed = 0; m_hit = 0; m_stop = 1; m_refp = 0; m_strap = '0;
      m_se_run = '0; m_se_prev = '0; m_dp_run = '0; m_dp_prev = '0;
      return;
    end
    req    = !(m_armed && m_s2);
    rise   = dp_src_c_i[0] && !m_refp;
    n_stop = m_stop; n_hit = m_hit;
    if (!req) begin n_stop = 0; n_hit = 0; end
    else if (rise && !m_stop) begin
      if (m_hit) n_stop = 1; else n_hit = 1;
    end
    for (int i = 0; i < N_SE; i++) begin
      if (m_se_run[i] && m_stop && m_se_prev[i] && !se_src_i[i]) m_se_run[i] = 0;
      else if (!m_se_run[i] && !m_stop && !se_src_i[i]) m_se_run[i] = 1;
      m_se_prev[i] = se_src_i[i];
    end
    for (int i = 0; i < N_DP; i++) begin
      if (m_dp_run[i] && m_stop && m_dp_prev[i] && !dp_src_c_i[i]) m_dp_run[i] = 0;
      else if (!m_dp_run[i] && !m_stop && !dp_src_c_i[i]) m_dp_run[i] = 1;
      m_dp_prev[i] = dp_src_c_i[i];
    end
    if (m_s2 && !m_armed) begin m_armed = 1; m_strap = strap_i; end
    m_refp = dp_src_c_i[0];
    m_stop = n_stop; m_hit = n_hit;
    m_s2 = m_s1; m_s1 = pg_pd_i;
  endtask

  task automatic step();
    @(negedge clk_i);
    model_step();
    for (int i = 0; i < N_SE; i++)
      chk(se_clk_o[i] == (m_se_run[i] & se_src_i[i]), "R5 se_clk", se_clk_o[i], m_se_run[i] & se_src_i[i]);
    for (int i = 0; i < N_DP; i++) begin
      chk(dp_t_o[i] == (m_dp_run[i] ? dp_src_t_i[i] : 1'b1), "R6 dp_t", dp_t_o[i], m_dp_run[i] ? dp_src_t_i[i] : 1'b1);
      chk(dp_c_o[i] == (m_dp_run[i] ? dp_src_c_i[i] : 1'b0), "R6 dp_c", dp_c_o[i], m_dp_run[i] ? dp_src_c_i[i] : 1'b0);
      chk(dp_t_oe_o[i] == (m_dp_run[i] | !drive_mode_i[i]), "R7 t_oe", dp_t_oe_o[i], m_dp_run[i] | !drive_mode_i[i]);
      chk(dp_c_oe_o[i] == m_dp_run[i], "R7 c_oe", dp_c_oe_o[i], m_dp_run[i]);
    end
    chk(parked_o == ~|{m_se_run, m_dp_run}, "R9 parked", parked_o, ~|{m_se_run, m_dp_run});
    chk(strap_vld_o == m_armed && strap_q_o == m_strap, "R2 strap", {strap_vld_o, strap_q_o}, {m_armed, m_strap});
    if (rst_ni) begin
      // full-width pulses: R5 and R8
      for (int i = 0; i < N_SE; i++) begin
        if (se_clk_o[i]) se_hi[i]++;
        else begin
          if (se_hi[i] != 0) chk(se_hi[i] == se_half(i), "R8 se pulse width", se_hi[i], se_half(i));
          se_hi[i] = 0;
        end
      end
      for (int i = 0; i < N_DP; i++) begin
        if (!dp_t_o[i]) dp_lo[i]++;
        else begin
          if (dp_lo[i] != 0) chk(dp_lo[i] == dp_half(i), "R8 dp low width", dp_lo[i], dp_half(i));
          dp_lo[i] = 0;
        end
      end
    end
    cyc++;
    drive_src();
  endtask

  initial begin
    bit seen;
    int hold;
    void'($urandom(32'd4242));
    for (int i = 0; i < N_SE; i++) se_hi[i] = 0;
    for (int i = 0; i < N_DP; i++) dp_lo[i] = 0;
    rst_ni = 0; pg_pd_i = 0; strap_i = '0; drive_mode_i = '0;
    drive_src();
    repeat (4) step();
    chk(se_clk_o == '0 && dp_t_o == '1 && dp_c_o == '0 && dp_c_oe_o == '0, "R1 reset levels",
        {se_clk_o, dp_t_o, dp_c_o, dp_c_oe_o}, {2'b00, 2'b11, 2'b00, 2'b00});
    chk(parked_o && !strap_vld_o, "R1 reset flags", {parked_o, strap_vld_o}, 2'b10);
    rst_ni = 1;
    repeat (20) step();
    chk(parked_o && !strap_vld_o, "R3 parked before power-good", {parked_o, strap_vld_o}, 2'b10);
    strap_i = 4'hA; pg_pd_i = 1;
    repeat (40) step();
    chk(strap_vld_o && strap_q_o == 4'hA, "R2 strap capture", strap_q_o, 4'hA);
    chk(!parked_o && se_clk_o !== 'x, "R8 running after power-good", parked_o, 0);
    // request narrower than one reference period
    strap_i = 4'h5; pg_pd_i = 0; step(); step(); pg_pd_i = 1;
    seen = 0;
    repeat (30) begin step(); if (parked_o || dp_c_oe_o != '1) seen = 1; end
    chk(!seen, "R4 short request ignored", seen, 0);
    chk(strap_q_o == 4'hA, "R10 strap kept", strap_q_o, 4'hA);
    drive_mode_i = 2'b10; pg_pd_i = 0;
    repeat (60) step();
    chk(parked_o, "R9 parked after stop", parked_o, 1);
    chk(se_clk_o == '0, "R5 se low when parked", se_clk_o, 0);
    chk(dp_t_o == '1 && dp_c_o == '0, "R6 pair levels parked", {dp_t_o, dp_c_o}, 4'b1100);
    chk(dp_t_oe_o == 2'b01 && dp_c_oe_o == 2'b00, "R7 mixed park modes", {dp_t_oe_o, dp_c_oe_o}, 4'b0100);
    pg_pd_i = 1;
    repeat (40) step();
    chk(!parked_o && dp_c_oe_o == '1, "R8 restart", {parked_o, dp_c_oe_o}, 3'b011);
    repeat (3000) begin
      hold = 1 + int'($urandom % 40);
      pg_pd_i = ($urandom % 3) != 0;
      drive_mode_i = N_DP'($urandom);
      strap_i = SW'($urandom);
      repeat (hold) step();
    end
    chk(strap_q_o == 4'hA, "R10 strap after random phase", strap_q_o, 4'hA);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule